// File: doc/BRIEF.md
# Palette DAC Host Register Port

This block is the processor-side front end of a palette DAC. Software reaches it through four byte-wide ports that share one 8-bit index register. The first port loads that index. The second stores cursor colour bytes. The third reads and writes a small set of indirect control registers. The fourth streams colour lookup table entries as red, green and blue bytes.

The block collects each colour entry from three consecutive data writes. It presents the complete entry on a one-cycle write port towards an external 256-entry table, then steps the index forward. Cursor colour writes step the index as well.

The control registers drive decoded outputs for the pixel path: pixel depth, clock divisor and a test flag. Digital-to-analog conversion and pixel lookup sit outside this block.

Top module: `rdac_host_port`

## Requirements
- R1: After a synchronous reset the following hold: index 0, component count 0, every cursor byte 0, cursor position 0, the misc, double-buffer and test registers 0, `tbl_we` 0 and `rd_data` 0. Because the misc register is 0, the decoded outputs show 8 bits per pixel and a divisor of 2.
- R2: Port select codes are 0 = index, 1 = cursor data, 2 = indirect register, 3 = colour data, the same for `wr_sel` and `rd_sel`. A write to port 0 loads the index and resets the component count to zero, so a partly written colour entry is abandoned.
- R3: Colour data writes are gathered in order. On the third write, `tbl_we` is high for exactly the following cycle. In that cycle `tbl_addr` holds the index as it was before the write, and `tbl_rgb` holds {first, second, third} with the first byte in bits [23:16]. The index then increments and the count returns to zero.
- R4: A cursor data write stores the byte in cursor slot (index mod 24), seen on `cur_bytes[8*slot +: 8]`, and increments the index.
- R5: An indirect write with index 8'h10 replaces `cur_pos[15:8]`. With index 8'h11 it replaces `cur_pos[7:0]`. The other half of `cur_pos` is kept in both cases.
- R6: An indirect write with index 8'h20 loads the misc register, 8'h21 the double-buffer register and 8'h22 the test register. An indirect write with any other index changes no register. Indirect writes leave the index unchanged.
- R7: A read returns data on `rd_data` one cycle later. The value is the misc register when `rd_sel` is 2 and the index is 8'h20, and 0 in every other case. A read uses the index and register values from before any write in the same cycle.
- R8: Misc bits [3:2] give the pixel depth: 0 gives 8 bits per pixel, 1 gives 16, 2 gives 32. Code 3 raises `depth_bad` and drives `depth_bpp` to 0.
- R9: Misc bits [7:6] give `clk_div` = 2^(field+1), that is 2, 4, 8 or 16.
- R10: Auto-increment of the index wraps from 255 to 0.
- R11: `test_active` follows bit 0 of the test register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Port selected for the write |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Port selected for the read |
| rd_data | output | 8 | Read byte, one cycle after rd_en |
| tbl_we | output | 1 | Colour table write pulse |
| tbl_addr | output | 8 | Colour table entry address |
| tbl_rgb | output | 24 | Colour table entry {red, green, blue} |
| cur_bytes | output | 192 | Cursor colour bytes, slot k at [8k+7:8k] |
| cur_pos | output | 16 | Cursor position |
| misc_ctrl | output | 8 | Misc control register |
| dbuf_ctrl | output | 8 | Double-buffer control register |
| test_ctrl | output | 8 | Test control register |
| depth_bpp | output | 6 | Decoded bits per pixel, 0 if invalid |
| depth_bad | output | 1 | Invalid pixel depth code |
| clk_div | output | 5 | Decoded clock divisor |
| test_active | output | 1 | Test mode flag |

## Verification
A read and a write have separate strobes and selects, so a read of the indirect port can fall in the same cycle as a write that moves the index or rewrites the misc register. The bench provokes both cases. It first points the index at the misc register, then reads the indirect port while writing a new index. Separately, it reads the indirect port while writing the misc register with a new value. In both cases the returned byte must reflect the state before the edge: the old index still selects misc, and the old misc value is the one returned. A follow-up read then confirms that the write itself took effect.

// File: rtl/rdac_pkg.sv
package rdac_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_CURS = 2'd1,
    PORT_IND  = 2'd2,
    PORT_CLUT = 2'd3
  } port_e;

  localparam logic [7:0] IX_POS_HI = 8'h10;
  localparam logic [7:0] IX_POS_LO = 8'h11;
  localparam logic [7:0] IX_MISC   = 8'h20;
  localparam logic [7:0] IX_DBUF   = 8'h21;
  localparam logic [7:0] IX_TEST   = 8'h22;
endpackage

// File: rtl/rdac_addr_seq.sv
module rdac_addr_seq
  import rdac_pkg::*;
#(
  parameter int DW    = 8,
  parameter int COMPS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       addr_q,
  output logic                tbl_we,
  output logic [DW-1:0]       tbl_addr,
  output logic [COMPS*DW-1:0] tbl_rgb
);
  localparam int IW = $clog2(COMPS);
  localparam int NB = COMPS - 1;

  logic [IW-1:0]      idx_q;
  logic [DW-1:0]      buf_q [NB];
  logic [COMPS*DW-1:0] rgb_next;

  wire addr_wr = wr_en && (wr_sel == PORT_ADDR);
  wire clut_wr = wr_en && (wr_sel == PORT_CLUT);
  wire curs_wr = wr_en && (wr_sel == PORT_CURS);
  wire last    = (idx_q == IW'(COMPS - 1));

  always_comb begin
    rgb_next = '0;
    for (int k = 0; k < NB; k++) begin
      rgb_next[(COMPS-1-k)*DW +: DW] = buf_q[k];
    end
    rgb_next[DW-1:0] = wr_data;
  end

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_buf
      always_ff @(posedge clk) begin
        if (rst) begin
          buf_q[g] <= '0;
        end else if (clut_wr && !last && (idx_q == IW'(g))) begin
          buf_q[g] <= wr_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      idx_q    <= '0;
      tbl_we   <= 1'b0;
      tbl_addr <= '0;
      tbl_rgb  <= '0;
    end else begin
      tbl_we <= 1'b0;
      if (addr_wr) begin
        addr_q <= wr_data;
        idx_q  <= '0;
      end else if (clut_wr) begin
        if (last) begin
          tbl_we   <= 1'b1;
          tbl_addr <= addr_q;
          tbl_rgb  <= rgb_next;
          addr_q   <= addr_q + 1'b1;
          idx_q    <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (curs_wr) begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  // R3: the component count never leaves its legal range
  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
    idx_q < IW'(COMPS));

  // R2: an index write lands and clears the count
  p_addr_load_r2: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> (addr_q == $past(wr_data)) && (idx_q == '0));

  // R3 / R10: a commit pulses the table and steps the index (wrapping)
  p_commit_r3: assert property (@(posedge clk) disable iff (rst)
    (clut_wr && last) |=> tbl_we && (tbl_addr == $past(addr_q)) &&
                          (addr_q == $past(addr_q) + 1'b1));

  // R3: the table write is a single-cycle pulse
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> !tbl_we);

  // R4: a cursor write steps the index
  p_curs_inc_r4: assert property (@(posedge clk) disable iff (rst)
    curs_wr |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/rdac_cursor_bank.sv
module rdac_cursor_bank
  import rdac_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NBYTES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [DW-1:0]        addr,
  input  logic [DW-1:0]        wr_data,
  output logic [NBYTES*DW-1:0] cur_bytes
);
  localparam int CW = $clog2(NBYTES);

  logic [DW-1:0] slot_full;
  logic [CW-1:0] slot;

  wire curs_wr = wr_en && (wr_sel == PORT_CURS);

  assign slot_full = addr % DW'(NBYTES);
  assign slot      = slot_full[CW-1:0];

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          cur_bytes[g*DW +: DW] <= '0;
        end else if (curs_wr && (slot == CW'(g))) begin
          cur_bytes[g*DW +: DW] <= wr_data;
        end
      end
    end
  endgenerate

  // R4: the slot stays below the bank size
  p_slot_range_r4: assert property (@(posedge clk) disable iff (rst)
    slot < CW'(NBYTES));

  // R4: bytes only change on a cursor write
  p_curs_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !curs_wr |=> $stable(cur_bytes));
endmodule

// File: rtl/rdac_ctrl_regs.sv
module rdac_ctrl_regs
  import rdac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  input  logic [DW-1:0] addr,
  output logic [DW-1:0] rd_data,
  output logic [2*DW-1:0] cur_pos,
  output logic [DW-1:0] misc_ctrl,
  output logic [DW-1:0] dbuf_ctrl,
  output logic [DW-1:0] test_ctrl,
  output logic [5:0]    depth_bpp,
  output logic          depth_bad,
  output logic [4:0]    clk_div,
  output logic          test_active
);
  wire ind_wr = wr_en && (wr_sel == PORT_IND);
  wire misc_wr = ind_wr && (addr == DW'(IX_MISC));
  wire test_wr = ind_wr && (addr == DW'(IX_TEST));

  logic [5:0] bpp_next;
  logic       bad_next;
  logic [4:0] div_next;

  always_comb begin
    bad_next = 1'b0;
    case (wr_data[3:2])
      2'd0:    bpp_next = 6'd8;
      2'd1:    bpp_next = 6'd16;
      2'd2:    bpp_next = 6'd32;
      default: begin
        bpp_next = 6'd0;
        bad_next = 1'b1;
      end
    endcase
    case (wr_data[7:6])
      2'd0:    div_next = 5'd2;
      2'd1:    div_next = 5'd4;
      2'd2:    div_next = 5'd8;
      default: div_next = 5'd16;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pos   <= '0;
      misc_ctrl <= '0;
      dbuf_ctrl <= '0;
      test_ctrl <= '0;
    end else if (ind_wr) begin
      case (addr)
        DW'(IX_POS_HI): cur_pos[2*DW-1:DW] <= wr_data;
        DW'(IX_POS_LO): cur_pos[DW-1:0]    <= wr_data;
        DW'(IX_MISC):   misc_ctrl          <= wr_data;
        DW'(IX_DBUF):   dbuf_ctrl          <= wr_data;
        DW'(IX_TEST):   test_ctrl          <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_bpp   <= 6'd8;
      depth_bad   <= 1'b0;
      clk_div     <= 5'd2;
      test_active <= 1'b0;
    end else begin
      if (misc_wr) begin
        depth_bpp <= bpp_next;
        depth_bad <= bad_next;
        clk_div   <= div_next;
      end
      if (test_wr) begin
        test_active <= wr_data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en && (rd_sel == PORT_IND) && (addr == DW'(IX_MISC))) begin
      rd_data <= misc_ctrl;
    end else begin
      rd_data <= '0;
    end
  end

  // R7: reads that do not select misc return zero
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && (rd_sel == PORT_IND) && (addr == DW'(IX_MISC))) |=> (rd_data == '0));

  // R5: a low-half position write keeps the high half
  p_pos_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (ind_wr && (addr == DW'(IX_POS_LO))) |=>
      (cur_pos[DW-1:0] == $past(wr_data)) &&
      (cur_pos[2*DW-1:DW] == $past(cur_pos[2*DW-1:DW])));

  // R8: an invalid depth reports zero bits per pixel
  p_depth_bad_r8: assert property (@(posedge clk) disable iff (rst)
    depth_bad |-> (depth_bpp == 6'd0) && (misc_ctrl[3:2] == 2'd3));

  // R11: the test flag follows bit 0 of the test register
  p_test_flag_r11: assert property (@(posedge clk) disable iff (rst)
    test_active == test_ctrl[0]);
endmodule

// File: rtl/rdac_host_port.sv
module rdac_host_port
  import rdac_pkg::*;
#(
  parameter int DW     = 8,
  parameter int COMPS  = 3,
  parameter int NBYTES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [1:0]           rd_sel,
  output logic [DW-1:0]        rd_data,
  output logic                 tbl_we,
  output logic [DW-1:0]        tbl_addr,
  output logic [COMPS*DW-1:0]  tbl_rgb,
  output logic [NBYTES*DW-1:0] cur_bytes,
  output logic [2*DW-1:0]      cur_pos,
  output logic [DW-1:0]        misc_ctrl,
  output logic [DW-1:0]        dbuf_ctrl,
  output logic [DW-1:0]        test_ctrl,
  output logic [5:0]           depth_bpp,
  output logic                 depth_bad,
  output logic [4:0]           clk_div,
  output logic                 test_active
);
  logic [DW-1:0] addr_q;

  rdac_addr_seq #(.DW(DW), .COMPS(COMPS)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_q(addr_q), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_rgb(tbl_rgb)
  );

  rdac_cursor_bank #(.DW(DW), .NBYTES(NBYTES)) u_curs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .addr(addr_q),
    .wr_data(wr_data), .cur_bytes(cur_bytes)
  );

  rdac_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .addr(addr_q), .rd_data(rd_data),
    .cur_pos(cur_pos), .misc_ctrl(misc_ctrl), .dbuf_ctrl(dbuf_ctrl),
    .test_ctrl(test_ctrl), .depth_bpp(depth_bpp), .depth_bad(depth_bad),
    .clk_div(clk_div), .test_active(test_active)
  );

  // R6: an indirect write leaves the index where it was
  p_ind_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel == PORT_IND)) |=> (addr_q == $past(addr_q)));
endmodule

// File: tb/rdac_host_port_test.sv
module rdac_host_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data, tbl_addr, misc_ctrl, dbuf_ctrl, test_ctrl;
  logic tbl_we, depth_bad, test_active;
  logic [23:0] tbl_rgb;
  logic [191:0] cur_bytes;
  logic [15:0] cur_pos;
  logic [5:0] depth_bpp;
  logic [4:0] clk_div;

  always #10 clk = ~clk;

  rdac_host_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_rgb(tbl_rgb), .cur_bytes(cur_bytes),
    .cur_pos(cur_pos), .misc_ctrl(misc_ctrl), .dbuf_ctrl(dbuf_ctrl),
    .test_ctrl(test_ctrl), .depth_bpp(depth_bpp), .depth_bad(depth_bad),
    .clk_div(clk_div), .test_active(test_active)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [7:0] m_addr = 0;
  int m_idx = 0;
  logic [7:0] m_buf [2];
  logic [191:0] m_cur = '0;

  task automatic chk(string req, logic [191:0] act, logic [191:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each table write with the queued entry
  always @(negedge clk) begin
    if (!rst && tbl_we) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected write", {8'd0, tbl_addr, tbl_rgb}, 32'hFFFFFFFF);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R3 table write", {8'd0, tbl_addr, tbl_rgb}, e);
      end
    end
  end

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    case (s)
      2'd0: begin m_addr = d; m_idx = 0; end
      2'd1: begin m_cur[(m_addr % 24)*8 +: 8] = d; m_addr++; end
      2'd3: begin
        if (m_idx == 2) begin
          exp_q.push_back({8'd0, m_addr, m_buf[0], m_buf[1], d});
          m_addr++; m_idx = 0;
        end else begin
          m_buf[m_idx] = d; m_idx++;
        end
      end
      default: ;
    endcase
  endtask

  task automatic rgb(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    wr(2'd3, a); wr(2'd3, b); wr(2'd3, c);
  endtask

  task automatic rd(logic [1:0] s, logic [7:0] exp, string req);
    rd_en = 1; rd_sel = s;
    @(posedge clk); #1;
    rd_en = 0;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tbl_we", tbl_we, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 cursor", cur_bytes, 0);
    chk("R1 pos", cur_pos, 0);
    chk("R1 regs", {misc_ctrl, dbuf_ctrl, test_ctrl}, 0);
    chk("R1 decode", {depth_bpp, depth_bad, clk_div, test_active}, {6'd8, 1'b0, 5'd2, 1'b0});

    // R3 two consecutive entries
    wr(2'd0, 8'd5);
    rgb(8'hAA, 8'hBB, 8'hCC);
    rgb(8'h11, 8'h22, 8'h33);
    // R2 index write abandons a partial entry
    wr(2'd0, 8'd40);
    wr(2'd3, 8'h01); wr(2'd3, 8'h02);
    wr(2'd0, 8'd50);
    rgb(8'h03, 8'h04, 8'h05);
    // R10 wrap from 255 to 0
    wr(2'd0, 8'hFF);
    rgb(8'h10, 8'h20, 8'h30);
    rgb(8'h40, 8'h50, 8'h60);

    // R4 cursor slots modulo 24
    wr(2'd0, 8'd30);
    wr(2'd1, 8'h5A); wr(2'd1, 8'h6B);
    wr(2'd0, 8'd23);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22);
    @(negedge clk);
    chk("R4 cursor bytes", cur_bytes, m_cur);
    rgb(8'h77, 8'h88, 8'h99); // index now 25
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'hE1); wr(2'd1, 8'hE2); // slots 14 and 15, index wraps to 0 (R10)
    rgb(8'h0A, 8'h0B, 8'h0C);
    @(negedge clk);
    chk("R4 cursor wrap", cur_bytes, m_cur);

    // R5 cursor position
    wr(2'd0, 8'h10); wr(2'd2, 8'h12);
    wr(2'd0, 8'h11); wr(2'd2, 8'h34);
    @(negedge clk);
    chk("R5 pos", cur_pos, 16'h1234);
    wr(2'd0, 8'h10); wr(2'd2, 8'hAB);
    @(negedge clk);
    chk("R5 pos high only", cur_pos, 16'hAB34);

    // R6 / R8 / R9 / R11 register writes
    wr(2'd0, 8'h20); wr(2'd2, 8'hC8);
    @(negedge clk);
    chk("R6 misc", misc_ctrl, 8'hC8);
    chk("R8 depth 32", {depth_bpp, depth_bad}, {6'd32, 1'b0});
    chk("R9 div 16", clk_div, 5'd16);
    wr(2'd0, 8'h21); wr(2'd2, 8'h05);
    wr(2'd0, 8'h22); wr(2'd2, 8'h01);
    @(negedge clk);
    chk("R6 dbuf", dbuf_ctrl, 8'h05);
    chk("R11 flag on", {test_ctrl, test_active}, {8'h01, 1'b1});
    // R6 unknown index and index unchanged by indirect writes
    wr(2'd0, 8'h30); wr(2'd2, 8'hFF);
    @(negedge clk);
    chk("R6 unknown index", {cur_pos, misc_ctrl, dbuf_ctrl, test_ctrl},
        {16'hAB34, 8'hC8, 8'h05, 8'h01});
    rgb(8'h31, 8'h32, 8'h33); // must commit at 8'h30
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h04); @(negedge clk);
    chk("R8 depth 16", {depth_bpp, depth_bad}, {6'd16, 1'b0});
    chk("R9 div 2", clk_div, 5'd2);
    wr(2'd2, 8'h4C); @(negedge clk);
    chk("R8 depth invalid", {depth_bpp, depth_bad}, {6'd0, 1'b1});
    chk("R9 div 4", clk_div, 5'd4);
    wr(2'd2, 8'h80); @(negedge clk);
    chk("R8 depth 8", {depth_bpp, depth_bad}, {6'd8, 1'b0});
    chk("R9 div 8", clk_div, 5'd8);

    // R7 reads
    rd(2'd2, 8'h80, "R7 misc read");
    rd(2'd0, 8'h00, "R7 index port read");
    rd(2'd3, 8'h00, "R7 colour port read");
    // same cycle: read with index write sees the old index
    rd_en = 1; rd_sel = 2'd2;
    wr(2'd0, 8'h21);
    rd_en = 0;
    @(negedge clk);
    chk("R7 read vs index write", rd_data, 8'h80);
    rd(2'd2, 8'h00, "R7 other index read");
    // same cycle: read with misc write sees the old value
    wr(2'd0, 8'h20);
    rd_en = 1; rd_sel = 2'd2;
    wr(2'd2, 8'h44);
    rd_en = 0;
    @(negedge clk);
    chk("R7 read vs misc write", rd_data, 8'h80);
    rd(2'd2, 8'h44, "R7 misc after write");

    // R11 flag off
    wr(2'd0, 8'h22); wr(2'd2, 8'h02);
    @(negedge clk);
    chk("R11 flag off", test_active, 1'b0);

    repeat (3) @(negedge clk);
    chk("R3 pending entries", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1;
    $finish;
  end
endmodule